// File: doc/BRIEF.md
# ADC Output Data Formatter

This block is the last digital stage of a 14-bit converter. Each clock it takes a raw sample coded in straight offset binary and two over-range flags, one for overdrive beyond the top of the range and one for overdrive below the bottom. It registers a 14-bit output word, an over-range bit and a drive enable for the output pads.

A format input selects between offset binary and two's complement. A 2-bit test-mode input can replace the sample with a fixed all-zeros pattern, a fixed all-ones pattern or a pattern that toggles every bit. Saturation codes and test patterns are built in offset binary first. They then pass through the same format conversion as live data. The pad drive enable is dropped when the output enable is low or power-down is high. The pads themselves, which turn the enable into high impedance, sit outside this block.

Top module: `adc_out_formatter`

## Requirements
- R1: While `rst_n` is low at a rising edge, the next outputs are `data_word` = 0x0000, `ovr_flag` = 0 and `data_drive` = 0.
- R2: Every output is registered once. Inputs present at rising edge k appear on the outputs just after edge k.
- R3: With `test_mode` = 00 (live data) and no overdrive flag, `data_word` equals `raw_sample` when `twos_fmt` = 0. When `twos_fmt` = 1 it equals `raw_sample` with bit 13 inverted.
- R4: With `test_mode` = 00 and `ovr_hi` = 1, `data_word` is 0x3FFF in offset binary and 0x1FFF in two's complement, whatever `raw_sample` is. `ovr_hi` wins when both flags are set.
- R5: With `test_mode` = 00, `ovr_lo` = 1 and `ovr_hi` = 0, `data_word` is 0x0000 in offset binary and 0x2000 in two's complement.
- R6: In live-data mode, `ovr_flag` is 1 exactly when either overdrive flag is set or `raw_sample` is 0x0000 or 0x3FFF. In any test mode `ovr_flag` is 0.
- R7: `test_mode` = 01 gives the offset-binary word 0x0000 and `test_mode` = 10 gives 0x3FFF. In two's complement these become 0x2000 and 0x1FFF. The overdrive flags and `raw_sample` have no effect in these modes.
- R8: `test_mode` = 11 outputs a free-running pattern in which every bit inverts at each clock. The pattern captured at the first edge after reset is all zeros. In two's complement, bit 13 of the pattern is inverted.
- R9: `data_drive` is 1 only when, at the previous edge, `out_en` was 1 and `pwr_down` was 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| raw_sample | input | 14 | Raw conversion result, offset binary |
| ovr_hi | input | 1 | Overdrive above the top of the range |
| ovr_lo | input | 1 | Overdrive below the bottom of the range |
| twos_fmt | input | 1 | 1 = two's complement output, 0 = offset binary |
| test_mode | input | 2 | 00 live, 01 zeros, 10 ones, 11 toggle |
| out_en | input | 1 | Output enable, active high |
| pwr_down | input | 1 | Power-down, active high |
| data_word | output | 14 | Registered output word |
| ovr_flag | output | 1 | Output sits at a full-scale limit |
| data_drive | output | 1 | Pad drive enable; 0 means high impedance |

## Verification
The hardest case to reach from the ports is the phase of the toggle pattern. The pattern runs freely from reset, so its value in any later cycle depends on how many edges have passed. The bench therefore applies a reset with toggle mode already selected and checks the all-zeros start and the alternation that follows, in both formats. Away from reset it checks only that each sample is the complement of the one before. Every raw code is also swept in both formats, so the full-scale edge codes of the over-range bit are covered.

// File: rtl/adc_fmt_pkg.sv
// Package: shared mode encoding and code constants for the output formatter.
// Assumes: the formatter's word width matches FMT_W where these helpers are used.
package adc_fmt_pkg;

    localparam int FMT_W = 14;

    // Test-mode selection; the encoding is visible at the block's port.
    typedef enum logic [1:0] {
        MODE_LIVE   = 2'b00,
        MODE_ZEROS  = 2'b01,
        MODE_ONES   = 2'b10,
        MODE_TOGGLE = 2'b11
    } test_mode_e;

endpackage

// File: rtl/fmt_toggle_gen.sv
// Module: fmt_toggle_gen
// Produces the toggle test pattern: every bit inverts on every clock.
// Assumes: the pattern runs freely from reset, whatever mode is selected, so
// the phase depends only on the number of edges since reset.
module fmt_toggle_gen #(
    parameter int W = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] pattern
);

    logic phase_q;

    // Free-running phase bit, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= 1'b0;
        else        phase_q <= ~phase_q;
    end

    // Replicate the phase bit across the word.
    assign pattern = {W{phase_q}};

    // R8
    toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (pattern == ~$past(pattern)));

endmodule

// File: rtl/fmt_code_map.sv
// Module: fmt_code_map
// Combinational core: chooses the offset-binary word (live sample, saturation
// code or test pattern), flags full-scale limits, then applies format conversion.
// Assumes: the high overdrive flag has priority over the low one; the limit flag
// is reported only for live data.
module fmt_code_map
    import adc_fmt_pkg::*;
#(
    parameter int W = 14
) (
    input  logic [W-1:0] raw,
    input  logic         sat_hi,
    input  logic         sat_lo,
    input  logic         twos,
    input  logic [1:0]   mode,
    input  logic [W-1:0] toggle_pat,
    output logic [W-1:0] word,
    output logic         at_limit
);

    localparam logic [W-1:0] CODE_TOP = {W{1'b1}};
    localparam logic [W-1:0] CODE_BOT = {W{1'b0}};
    localparam logic [W-1:0] SIGN_BIT = {1'b1, {(W-1){1'b0}}};

    test_mode_e   mode_e;
    logic [W-1:0] ob_word;

    assign mode_e = test_mode_e'(mode);

    // Select the word in offset binary according to mode and overdrive.
    always_comb begin
        unique case (mode_e)
            MODE_ZEROS:  ob_word = CODE_BOT;
            MODE_ONES:   ob_word = CODE_TOP;
            MODE_TOGGLE: ob_word = toggle_pat;
            default: begin
                if (sat_hi)      ob_word = CODE_TOP;
                else if (sat_lo) ob_word = CODE_BOT;
                else             ob_word = raw;
            end
        endcase
    end

    // Over-range flag: live data only, saturated or raw at either limit.
    always_comb begin
        if (mode_e == MODE_LIVE)
            at_limit = sat_hi | sat_lo | (raw == CODE_TOP) | (raw == CODE_BOT);
        else
            at_limit = 1'b0;
    end

    // Format conversion: two's complement flips only the most significant bit.
    always_comb begin
        word = twos ? (ob_word ^ SIGN_BIT) : ob_word;
    end

endmodule

// File: rtl/fmt_out_stage.sv
// Module: fmt_out_stage
// Output register for word, over-range bit and pad drive enable.
// Assumes: a synchronous reset clears every output; the drive enable follows the
// output-enable and power-down inputs with the same one-cycle latency as data.
module fmt_out_stage #(
    parameter int W = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] word_d,
    input  logic         limit_d,
    input  logic         oe,
    input  logic         pd,
    output logic [W-1:0] word_q,
    output logic         limit_q,
    output logic         drive_q
);

    // Capture the formatted word and its limit flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q  <= '0;
            limit_q <= 1'b0;
        end else begin
            word_q  <= word_d;
            limit_q <= limit_d;
        end
    end

    // Pad drive: enabled only when output enable is set and power-down is clear.
    always_ff @(posedge clk) begin
        if (!rst_n) drive_q <= 1'b0;
        else        drive_q <= oe & ~pd;
    end

    // R9
    pd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pd |=> !drive_q);

    // R9
    oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !oe |=> !drive_q);

    // R2
    word_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (word_q == $past(word_d)));

endmodule

// File: rtl/adc_out_formatter.sv
// Module: adc_out_formatter (top)
// Formats raw offset-binary samples for the parallel output: saturation on
// overdrive, test patterns, optional two's complement and pad drive gating.
// Assumes: one register stage from every input to every output; the pads that
// turn data_drive into high impedance are outside this block.
module adc_out_formatter
    import adc_fmt_pkg::*;
#(
    parameter int W = FMT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_sample,
    input  logic         ovr_hi,
    input  logic         ovr_lo,
    input  logic         twos_fmt,
    input  logic [1:0]   test_mode,
    input  logic         out_en,
    input  logic         pwr_down,
    output logic [W-1:0] data_word,
    output logic         ovr_flag,
    output logic         data_drive
);

    localparam logic [W-1:0] TOP_OB = {W{1'b1}};
    localparam logic [W-1:0] TOP_TC = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] BOT_TC = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0] toggle_pat;
    logic [W-1:0] fmt_word;
    logic         fmt_limit;

    fmt_toggle_gen #(.W(W)) u_toggle (
        .clk     (clk),
        .rst_n   (rst_n),
        .pattern (toggle_pat)
    );

    fmt_code_map #(.W(W)) u_map (
        .raw        (raw_sample),
        .sat_hi     (ovr_hi),
        .sat_lo     (ovr_lo),
        .twos       (twos_fmt),
        .mode       (test_mode),
        .toggle_pat (toggle_pat),
        .word       (fmt_word),
        .at_limit   (fmt_limit)
    );

    fmt_out_stage #(.W(W)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .word_d  (fmt_word),
        .limit_d (fmt_limit),
        .oe      (out_en),
        .pd      (pwr_down),
        .word_q  (data_word),
        .limit_q (ovr_flag),
        .drive_q (data_drive)
    );

    // R4
    sat_hi_ob_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (test_mode == MODE_LIVE && ovr_hi && !twos_fmt) |=> (data_word == TOP_OB));

    // R4
    sat_hi_tc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (test_mode == MODE_LIVE && ovr_hi && twos_fmt) |=> (data_word == TOP_TC));

    // R5
    sat_lo_tc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (test_mode == MODE_LIVE && ovr_lo && !ovr_hi && twos_fmt) |=> (data_word == BOT_TC));

    // R3
    live_tc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (test_mode == MODE_LIVE && !ovr_hi && !ovr_lo && twos_fmt)
        |=> (data_word == ($past(raw_sample) ^ BOT_TC)));

    // R6
    test_no_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (test_mode != MODE_LIVE) |=> !ovr_flag);

    // R7
    ones_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (test_mode == MODE_ONES) |=> (data_word == (twos_fmt ? TOP_TC : TOP_OB)) || $past(twos_fmt) != twos_fmt);

endmodule

// File: tb/adc_out_formatter_test.sv
`timescale 1ns/1ps
module adc_out_formatter_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] raw_sample = '0;
    logic        ovr_hi = 1'b0;
    logic        ovr_lo = 1'b0;
    logic        twos_fmt = 1'b0;
    logic [1:0]  test_mode = 2'b00;
    logic        out_en = 1'b1;
    logic        pwr_down = 1'b0;
    logic [13:0] data_word;
    logic        ovr_flag;
    logic        data_drive;

    int tests = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    adc_out_formatter uut (
        .clk(clk), .rst_n(rst_n), .raw_sample(raw_sample),
        .ovr_hi(ovr_hi), .ovr_lo(ovr_lo), .twos_fmt(twos_fmt),
        .test_mode(test_mode), .out_en(out_en), .pwr_down(pwr_down),
        .data_word(data_word), .ovr_flag(ovr_flag), .data_drive(data_drive)
    );

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Called at a negedge: drive inputs, let one rising edge pass, return at next negedge.
    task automatic step(input logic [13:0] r, input logic hi, input logic lo,
                        input logic tc, input logic [1:0] m);
        raw_sample = r; ovr_hi = hi; ovr_lo = lo; twos_fmt = tc; test_mode = m;
        @(negedge clk);
    endtask

    function automatic int fmt(input int ob, input logic tc);
        return tc ? (ob ^ 'h2000) : ob;
    endfunction

    initial begin : watchdog
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : main
        int prev;
        @(negedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1 data", data_word, 0);
        chk("R1 ovr", ovr_flag, 0);
        chk("R1 drive", data_drive, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R3 R6: exhaustive live sweep in both formats
        for (int f = 0; f < 2; f++) begin
            for (int v = 0; v < 16384; v++) begin
                step(v[13:0], 1'b0, 1'b0, f[0], 2'b00);
                chk("R3 live word", data_word, fmt(v, f[0]));
                chk("R6 edge ovr", ovr_flag, (v == 0 || v == 'h3FFF) ? 1 : 0);
            end
        end

        // R4 R5: overdrive saturation, several raw values
        for (int f = 0; f < 2; f++) begin
            for (int v = 1; v < 16384; v += 2731) begin
                step(v[13:0], 1'b1, 1'b0, f[0], 2'b00);
                chk("R4 hi sat", data_word, fmt('h3FFF, f[0]));
                chk("R6 hi ovr", ovr_flag, 1);
                step(v[13:0], 1'b0, 1'b1, f[0], 2'b00);
                chk("R5 lo sat", data_word, fmt(0, f[0]));
                chk("R6 lo ovr", ovr_flag, 1);
                step(v[13:0], 1'b1, 1'b1, f[0], 2'b00);
                chk("R4 priority", data_word, fmt('h3FFF, f[0]));
            end
        end

        // R7: fixed patterns ignore overdrive and raw data
        for (int f = 0; f < 2; f++) begin
            step(14'h1234, 1'b1, 1'b0, f[0], 2'b01);
            chk("R7 zeros", data_word, fmt(0, f[0]));
            chk("R6 test ovr", ovr_flag, 0);
            step(14'h0000, 1'b0, 1'b1, f[0], 2'b10);
            chk("R7 ones", data_word, fmt('h3FFF, f[0]));
            chk("R6 test ovr", ovr_flag, 0);
        end

        // R8: toggle mode, complement every cycle
        step(14'h0ABC, 1'b0, 1'b0, 1'b0, 2'b11);
        prev = data_word;
        chk("R8 toggle value", (prev == 0 || prev == 'h3FFF) ? 1 : 0, 1);
        for (int i = 0; i < 6; i++) begin
            step(14'h0ABC, 1'b0, 1'b0, 1'b0, 2'b11);
            chk("R8 toggle flip", data_word, prev ^ 'h3FFF);
            prev = data_word;
        end

        // R8: phase from reset, both formats
        for (int f = 0; f < 2; f++) begin
            rst_n = 1'b0;
            step(14'h0000, 1'b0, 1'b0, f[0], 2'b11);
            rst_n = 1'b1;
            step(14'h0000, 1'b0, 1'b0, f[0], 2'b11);
            chk("R8 first", data_word, fmt(0, f[0]));
            step(14'h0000, 1'b0, 1'b0, f[0], 2'b11);
            chk("R8 second", data_word, fmt('h3FFF, f[0]));
            step(14'h0000, 1'b0, 1'b0, f[0], 2'b11);
            chk("R8 third", data_word, fmt(0, f[0]));
        end

        // R9: drive gating, R2 latency of drive
        out_en = 1'b1; pwr_down = 1'b0;
        step(14'h0100, 1'b0, 1'b0, 1'b0, 2'b00);
        chk("R9 drive on", data_drive, 1);
        pwr_down = 1'b1;
        #1;
        chk("R2 drive held", data_drive, 1);
        step(14'h0100, 1'b0, 1'b0, 1'b0, 2'b00);
        chk("R9 pwr_down", data_drive, 0);
        pwr_down = 1'b0; out_en = 1'b0;
        step(14'h0100, 1'b0, 1'b0, 1'b0, 2'b00);
        chk("R9 out_en low", data_drive, 0);
        pwr_down = 1'b1;
        step(14'h0100, 1'b0, 1'b0, 1'b0, 2'b00);
        chk("R9 both off", data_drive, 0);
        out_en = 1'b1; pwr_down = 1'b0;
        step(14'h0100, 1'b0, 1'b0, 1'b0, 2'b00);
        chk("R9 restore", data_drive, 1);

        // R1: reset after activity
        rst_n = 1'b0;
        step(14'h3FFF, 1'b1, 1'b0, 1'b0, 2'b00);
        chk("R1 data again", data_word, 0);
        chk("R1 ovr again", ovr_flag, 0);
        chk("R1 drive again", data_drive, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule